// File: doc/BRIEF.md
# Strap-Addressed I2C Target Port

This block is the serial configuration port of a peripheral that only ever answers a bus controller and never starts a transfer itself. The raw SCL and SDA pad inputs pass through synchronizers. The block runs from a system clock at least sixteen times faster than SCL and controls the shared data line with a single open-drain pull-down enable.

The block recognizes start and stop conditions. The seven-bit target address is a fixed `1010` device-type prefix followed by three strap pins. The block acknowledges only its own address. In a write, the first data byte sets an internal register pointer and the bytes after it fill a small register array. In a read, bytes stream out of the array for as long as the controller acknowledges them. The pointer advances after every data byte and wraps at the end of the array.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset, and whenever no transfer is active, `sda_oe` is 0, so SDA is released.
- R2: SDA falling while SCL is high (start) begins reception of an address byte. SDA rising while SCL is high (stop) ends the transfer and releases SDA.
- R3: The address byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `strap_addr[2:0]`. On a match the port pulls SDA low during the ninth clock. Bit 0 selects the direction: 1 for read, 0 for write.
- R4: After an address that does not match, SDA stays released for every later clock until the next start or stop.
- R5: In a write, the first data byte loads the pointer with (byte mod REG_COUNT). Each later byte is stored at the pointer, and the pointer then advances. Every data byte is acknowledged.
- R6: In a read, the port sends the byte at the pointer, MSB first, and advances the pointer for each byte it sends. A read after a repeated start begins at the current pointer.
- R7: The pointer moves from REG_COUNT-1 to 0, for reads and for writes.
- R8: If the controller acknowledges a read byte (SDA low on the ninth clock), the next byte follows. If it does not, the port releases SDA until the next start or stop.
- R9: The port turns on its pull-down only while SCL is low.
- R10: A start or stop in the middle of a byte abandons that byte. After a start, the next eight bits are taken as a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL pad level |
| sda_in | input | 1 | Raw SDA pad level (the wired bus value) |
| strap_addr | input | 3 | Strapped low address bits |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench tries every pairing of strap value and low address bits, along with wrong device-type prefixes. A decoder that ignored one strap bit or the prefix would acknowledge addresses that belong to other targets. Sequential reads cross the end of the array, and a wrapped write starts near the top of it. A pointer that failed to wrap, or that advanced on the byte that loads it, would return bytes from the wrong locations. The bench also sends a byte after a not-acknowledge and expects all ones, so a port that kept driving would show up there. Finally, it aborts bytes partway with a start and with a stop. A bit counter that was not cleared would then misread the next address and withhold its acknowledge.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } slv_state_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign rise   = chain[STAGES-1] & ~prev;
  assign fall   = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_addr,
  output logic       sda_oe
);
  localparam int PTR_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .line_in(scl_in),
    .line_s(scl_s), .rise(scl_rise), .fall(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .line_in(sda_in),
    .line_s(sda_s), .rise(sda_rise), .fall(sda_fall));

  logic start_det, stop_det;
  assign start_det = scl_s & sda_fall;
  assign stop_det  = scl_s & sda_rise;

  slv_state_t       state;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh;
  logic             is_addr, rd_mode, ptr_set, mst_ack;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rd_data;
  logic             wr_en, addr_match, byte_done;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(REG_COUNT - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign addr_match = (rx_sh[7:1] == {DEV_TYPE, strap_addr});
  assign byte_done  = scl_fall && (bit_cnt == 4'd8);
  assign wr_en      = (state == ST_RX) && !start_det && !stop_det &&
                      byte_done && !is_addr && ptr_set;

  i2c_reg_array #(.DEPTH(REG_COUNT), .WIDTH(8)) u_regs (
    .clk(clk), .we(wr_en), .waddr(ptr), .wdata(rx_sh),
    .raddr(ptr), .rdata(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      is_addr <= 1'b0;
      rd_mode <= 1'b0;
      ptr_set <= 1'b0;
      mst_ack <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      state   <= ST_RX;
      bit_cnt <= '0;
      is_addr <= 1'b1;
      ptr_set <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (is_addr) begin
              if (addr_match) begin
                rd_mode <= rx_sh[0];
                sda_oe  <= 1'b1;
                state   <= ST_RX_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_RX_ACK;
              if (!ptr_set) begin
                ptr     <= PTR_W'(32'(rx_sh) % REG_COUNT);
                ptr_set <= 1'b1;
              end else begin
                ptr <= step(ptr);
              end
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            is_addr <= 1'b0;
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= step(ptr);
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (mst_ack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= step(ptr);
              state  <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: idle means released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R2: a stop always frees the line
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R4: a non-addressed port stays off the bus
  assert_ignore_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);
  // R8: a not-acknowledge from the controller ends driving
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK && scl_fall && !mst_ack && !start_det && !stop_det) |=> !sda_oe);
  // R9: the pull-down engages only with SCL low
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  // R10: a start rearms address reception from bit zero
  assert_start_rearm_R10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_RX && bit_cnt == 4'd0 && is_addr));
endmodule

// File: tb/i2c_strap_slave_test.sv
module i2c_strap_slave_test;
  localparam int Q = 8;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_strap_slave #(.REG_COUNT(NREG), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .strap_addr(strap), .sda_oe(sda_oe));

  int checks = 0;
  int errors = 0;
  int r9_bad = 0;
  logic oe_d = 1'b0;
  logic [7:0] model [NREG];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && sda_oe && !oe_d && scl) r9_bad++;
    oe_d = sda_oe;
  end

  task automatic bit_cycle(input logic b, output logic r);
    w(Q); sda_m = b; w(Q); scl = 1'b1; w(Q); r = sda_bus; w(Q); scl = 1'b0;
  endtask

  task automatic do_start();
    w(Q); sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0;
  endtask

  task automatic do_stop();
    w(Q); sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], r);
    bit_cycle(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      b[i] = r;
    end
    bit_cycle(!give_ack, r);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [7:0] wa, ra;
    w(5); rst = 1'b0; w(5);
    chk(sda_oe == 1'b0, "R1 reset released", int'(sda_oe), 0);

    // R3 / R4: full strap x address sweep
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        strap = 3'(s);
        do_start();
        send_byte({4'b1010, 3'(a), 1'b0}, ack);
        chk(ack == (a == s), "R3 address match", int'(ack), int'(a == s));
        if (a == (s ^ 1)) begin
          send_byte(8'h00, ack);
          chk(ack == 1'b0, "R4 stays released", int'(ack), 0);
        end
        do_stop();
        chk(sda_oe == 1'b0, "R2 stop releases", int'(sda_oe), 0);
      end
    end
    strap = 3'd5;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] pre;
      pre = (k == 0) ? 4'b1011 : (k == 1) ? 4'b0010 : (k == 2) ? 4'b1110 : 4'b0101;
      do_start();
      send_byte({pre, 3'd5, 1'b1}, ack);
      chk(ack == 1'b0, "R3 wrong prefix", int'(ack), 0);
      do_stop();
    end

    strap = 3'd3;
    wa = {4'b1010, 3'd3, 1'b0};
    ra = {4'b1010, 3'd3, 1'b1};

    // R5: fill array from pointer 0
    do_start();
    send_byte(wa, ack);
    chk(ack, "R2 start then address", int'(ack), 1);
    send_byte(8'h00, ack);
    chk(ack, "R5 pointer byte ack", int'(ack), 1);
    for (int i = 0; i < NREG; i++) begin
      model[i] = 8'(i * 29 + 7);
      send_byte(model[i], ack);
      chk(ack, "R5 data byte ack", int'(ack), 1);
    end
    do_stop();

    // R6 / R7 / R8: sequential read across the end of the array
    do_start();
    send_byte(wa, ack);
    send_byte(8'h00, ack);
    do_start();
    send_byte(ra, ack);
    chk(ack, "R6 read address ack", int'(ack), 1);
    for (int i = 0; i < NREG + 2; i++) begin
      recv_byte(i != NREG + 1, b);
      chk(b == model[i % NREG], (i >= NREG) ? "R7 read wrap" : "R6 sequential read",
          int'(b), int'(model[i % NREG]));
    end
    do_stop();

    // R7: write wrap from pointer 6
    do_start();
    send_byte(wa, ack);
    send_byte(8'h0E, ack);   // 14 mod 8 = 6
    for (int i = 0; i < 4; i++) begin
      model[(6 + i) % NREG] = 8'(8'hC0 + i);
      send_byte(8'(8'hC0 + i), ack);
    end
    do_stop();
    do_start();
    send_byte(wa, ack);
    send_byte(8'h05, ack);
    do_start();
    send_byte(ra, ack);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i != 4, b);
      chk(b == model[(5 + i) % NREG], "R7 write wrap", int'(b), int'(model[(5 + i) % NREG]));
    end
    do_stop();

    // R8: not-acknowledge stops the stream
    do_start();
    send_byte(wa, ack);
    send_byte(8'h02, ack);
    do_start();
    send_byte(ra, ack);
    recv_byte(1'b0, b);
    chk(b == model[2], "R8 single read", int'(b), int'(model[2]));
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R8 released after nack", int'(b), 8'hFF);
    do_stop();

    // R10: start and stop inside a byte
    do_start();
    bit_cycle(1'b1, ack); bit_cycle(1'b0, ack); bit_cycle(1'b1, ack);
    do_start();
    send_byte(wa, ack);
    chk(ack, "R10 start mid-byte", int'(ack), 1);
    send_byte(8'h04, ack);
    send_byte(8'h5A, ack);
    model[4] = 8'h5A;
    do_stop();
    do_start();
    bit_cycle(1'b1, ack); bit_cycle(1'b0, ack); bit_cycle(1'b1, ack); bit_cycle(1'b0, ack);
    do_stop();
    chk(sda_oe == 1'b0, "R10 stop mid-byte", int'(sda_oe), 0);
    do_start();
    send_byte(wa, ack);
    chk(ack, "R10 address after abort", int'(ack), 1);
    send_byte(8'h04, ack);
    do_start();
    send_byte(ra, ack);
    recv_byte(1'b0, b);
    chk(b == 8'h5A, "R10 data after abort", int'(b), 8'h5A);
    do_stop();

    w(10);
    chk(r9_bad == 0, "R9 pull only with SCL low", r9_bad, 0);
    chk(sda_oe == 1'b0, "R1 idle released", int'(sda_oe), 0);
    finish_up();
  end
endmodule